// File: doc/BRIEF.md
# Serial Port Buffer Status Controller

This block sits between a serial port's shift registers and the logic that writes outgoing words and reads incoming ones. On the transmit side a two-entry buffer collects words and hands them one at a time to the transmit shift register through a load handshake. It reports whether the buffer has room, based on a selectable threshold, and whether all queued traffic has left the shifter. On the receive side, each frame the receive shifter completes is placed in a two-entry buffer. When that buffer is full, the shifter itself keeps one more frame. Flags report data-valid and full.

Four single-cycle command strobes switch the transmitter and the receiver on and off. Reception can be blocked, and a frame that is in flight when the receiver is switched off is thrown away. An optional stereo mode labels successive words as left or right channel, alternating, and reports which channel the next read returns and which channel the transmit buffer wants next. Line timing, baud generation and register decoding belong to neighbouring blocks.

Top module: `sbuf_status_ctrl`

## Requirements
- R1: Transmitter and receiver each have an enable state that is 0 after reset. It is set by its enable strobe and cleared by its disable strobe, and the disable strobe wins when both strobes arrive in the same cycle. A disabled transmitter never asserts `tx_load`. A disabled receiver stores no frame.
- R2: The transmit buffer holds 2 words, and a write into a full buffer is ignored. `tx_load` is high, with the oldest word on `tx_load_data`, when the transmitter is enabled, the buffer is not empty and the shifter is idle. The shifter is busy from a load until `tx_frame_done`.
- R3: `tx_level` is 1 after reset. When `cfg_tx_half`=0 it is 1 only while the transmit buffer is empty. When `cfg_tx_half`=1 it is 1 while the buffer holds at most one word.
- R4: `tx_complete` rises on the edge of a `tx_frame_done` that finds the transmit buffer empty. It falls on the edge of any `tx_wr_valid`, and the clear takes priority.
- R5: `tx_tristated` is 1 while the transmitter is disabled and `cfg_auto_tri`=0. It is always 0 when `cfg_auto_tri`=1.
- R6: `rx_valid` is 1 while the receive buffer holds at least one frame. `rx_rd` removes the oldest frame, and `rx_rd_data` shows that frame.
- R7: `rx_full` is 1 while the receive buffer holds 2 frames. A frame that completes while the buffer is full waits in the shifter slot and enters the buffer on the edge after the one where a read frees an entry. A frame that completes while that slot is also occupied is lost. Frames are read in arrival order.
- R8: If `cmd_rx_dis` arrives between `rx_frame_start` and `rx_frame_done`, that frame is discarded, even if the receiver is enabled again before the frame completes.
- R9: A frame whose `rx_frame_done` occurs while `rx_block`=1 is discarded.
- R10: With `cfg_stereo`=1, received frames are tagged left (0) and right (1) alternately, starting with left after reset. The tag advances on every frame completed while the receiver is enabled, including discarded frames. `rx_right_next` is 1 when the oldest stored frame is right. `rx_full_right` is 1 when the buffer is full and every entry is right.
- R11: With `cfg_stereo`=1, accepted transmit writes alternate left/right, starting with left. `tx_exp_right` is 1 when the next write is taken as right. `tx_exp_dright` is 1 when, in addition, the transmit buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_tx_en | input | 1 | Transmitter enable strobe |
| cmd_tx_dis | input | 1 | Transmitter disable strobe |
| cmd_rx_en | input | 1 | Receiver enable strobe |
| cmd_rx_dis | input | 1 | Receiver disable strobe |
| cfg_tx_half | input | 1 | Transmit level threshold select (0 empty, 1 half-full) |
| cfg_auto_tri | input | 1 | Automatic driver tristate mode |
| cfg_stereo | input | 1 | Stereo left/right tracking |
| rx_block | input | 1 | Discard incoming frames |
| tx_wr_valid | input | 1 | Write a word into the transmit buffer |
| tx_wr_data | input | DATA_W | Word to transmit |
| tx_load | output | 1 | Transmit shifter takes `tx_load_data` this cycle |
| tx_load_data | output | DATA_W | Oldest transmit word |
| tx_frame_done | input | 1 | Transmit shifter finished its frame |
| rx_frame_start | input | 1 | Receive shifter began a frame |
| rx_frame_done | input | 1 | Receive shifter completed a frame |
| rx_frame_data | input | DATA_W | Completed receive frame |
| rx_rd | input | 1 | Read the oldest received frame |
| rx_rd_data | output | DATA_W | Oldest received frame |
| tx_level | output | 1 | Transmit buffer below threshold |
| tx_complete | output | 1 | All transmit traffic has left |
| tx_tristated | output | 1 | Transmit driver is off |
| rx_valid | output | 1 | Receive buffer not empty |
| rx_full | output | 1 | Receive buffer full |
| rx_right_next | output | 1 | Next read returns right-channel data |
| rx_full_right | output | 1 | Receive buffer full of right data |
| tx_exp_right | output | 1 | Next transmit write is right channel |
| tx_exp_dright | output | 1 | Transmit buffer empty and expecting right |

## Verification
The bench fills the receive buffer and then delivers two more frames. One must wait in the shifter slot and the other must vanish. A design without the extra slot would lose the third frame, and one that moved the waiting frame too early would show `rx_full` a cycle ahead of time. Write-to-full on the transmit side must not displace queued words, which the sequence of load words exposes. `tx_complete` must only rise when the buffer was empty at frame end. Also covered are a disable that arrives mid-frame followed by a quick re-enable, which an implementation that only looks at the enable state would accept, and simultaneous enable and disable strobes. In stereo mode, a blocked frame must still advance the channel tag, otherwise `rx_full_right` can never be reached.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   function automatic int unsigned occ_w(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = sbuf_pkg::occ_w(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sbuf_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("sbuf_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign do_pop  = pop && (count != '0);
   assign do_push = push && ((count != CW'(DEPTH)) || do_pop);
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= adv(wp);
         if (do_pop)  rp <= adv(rp);
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

endmodule

// File: rtl/sbuf_tx.sv
module sbuf_tx #(
   parameter int W         = 8,
   parameter int DEPTH     = 2,
   parameter bit STEREO_EN = 1'b1,
   localparam int CW       = sbuf_pkg::occ_w(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_en,
   input  logic         wr_valid,
   input  logic [W-1:0] wr_data,
   input  logic         frame_done,
   input  logic         half_sel,
   input  logic         stereo,
   output logic         load,
   output logic [W-1:0] load_data,
   output logic         level,
   output logic         complete,
   output logic         exp_right,
   output logic         exp_dright
);

   logic [CW-1:0] occ;
   logic          empty, full, wr_ok, sh_busy;

   sbuf_fifo #(.W(W), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_valid),
      .push_data (wr_data),
      .pop       (load),
      .head      (load_data),
      .count     (occ)
   );

   assign empty = (occ == '0);
   assign full  = (occ == CW'(DEPTH));
   assign load  = tx_en && !sh_busy && !empty;
   assign wr_ok = wr_valid && (!full || load);
   assign level = half_sel ? (occ <= CW'(DEPTH / 2)) : empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_busy  <= 1'b0;
         complete <= 1'b0;
      end else begin
         if (load)            sh_busy <= 1'b1;
         else if (frame_done) sh_busy <= 1'b0;
         if (wr_valid)                 complete <= 1'b0;
         else if (frame_done && empty) complete <= 1'b1;
      end
   end

   if (STEREO_EN) begin : g_stereo
      sbuf_pkg::chan_e next_ch;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         next_ch <= sbuf_pkg::CH_LEFT;
         else if (!stereo)   next_ch <= sbuf_pkg::CH_LEFT;
         else if (wr_ok)     next_ch <= (next_ch == sbuf_pkg::CH_LEFT) ?
                                        sbuf_pkg::CH_RIGHT : sbuf_pkg::CH_LEFT;
      end
      assign exp_right  = stereo && (next_ch == sbuf_pkg::CH_RIGHT);
      assign exp_dright = exp_right && empty;
   end else begin : g_mono
      assign exp_right  = 1'b0;
      assign exp_dright = 1'b0;
   end

endmodule

// File: rtl/sbuf_rx.sv
module sbuf_rx #(
   parameter int W         = 8,
   parameter int DEPTH     = 2,
   parameter bit STEREO_EN = 1'b1,
   localparam int CW       = sbuf_pkg::occ_w(DEPTH),
   localparam int EW       = W + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_en,
   input  logic         dis_cmd,
   input  logic         frame_start,
   input  logic         frame_done,
   input  logic [W-1:0] frame_data,
   input  logic         block,
   input  logic         rd,
   input  logic         stereo,
   output logic [W-1:0] rd_data,
   output logic         valid,
   output logic         full,
   output logic         right_next,
   output logic         full_right
);

   logic [CW-1:0] occ;
   logic [EW-1:0] head, push_word, slot_word;
   logic          slot_v, in_frame, aborted;
   logic          accept, slot_mv, push, tag;

   assign full      = (occ == CW'(DEPTH));
   assign valid     = (occ != '0);
   assign accept    = frame_done && rx_en && !aborted && !block;
   assign slot_mv   = slot_v && !full;
   assign push      = slot_mv || (accept && !slot_v && !full);
   assign push_word = slot_mv ? slot_word : {tag, frame_data};
   assign rd_data   = head[W-1:0];

   sbuf_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_word),
      .pop       (rd),
      .head      (head),
      .count     (occ)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         aborted   <= 1'b0;
         slot_v    <= 1'b0;
         slot_word <= '0;
      end else begin
         if (frame_start)     in_frame <= 1'b1;
         else if (frame_done) in_frame <= 1'b0;
         if (frame_start || frame_done) aborted <= 1'b0;
         else if (dis_cmd && in_frame)  aborted <= 1'b1;
         if (accept && (slot_mv || (!slot_v && full))) begin
            slot_v    <= 1'b1;
            slot_word <= {tag, frame_data};
         end else if (slot_mv) begin
            slot_v    <= 1'b0;
         end
      end
   end

   if (STEREO_EN) begin : g_stereo
      sbuf_pkg::chan_e cur_ch;
      logic [CW-1:0]   right_cnt;
      logic            pop_eff;
      assign pop_eff = rd && valid;
      assign tag     = stereo && (cur_ch == sbuf_pkg::CH_RIGHT);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur_ch    <= sbuf_pkg::CH_LEFT;
            right_cnt <= '0;
         end else begin
            if (!stereo)                  cur_ch <= sbuf_pkg::CH_LEFT;
            else if (frame_done && rx_en) cur_ch <= (cur_ch == sbuf_pkg::CH_LEFT) ?
                                                    sbuf_pkg::CH_RIGHT : sbuf_pkg::CH_LEFT;
            right_cnt <= right_cnt + CW'(push && push_word[W])
                                   - CW'(pop_eff && head[W]);
         end
      end
      assign right_next = stereo && valid && head[W];
      assign full_right = stereo && full && (right_cnt == CW'(DEPTH));
   end else begin : g_mono
      assign tag        = 1'b0;
      assign right_next = 1'b0;
      assign full_right = 1'b0;
   end

endmodule

// File: rtl/sbuf_status_ctrl.sv
module sbuf_status_ctrl #(
   parameter int DATA_W    = 8,
   parameter int TX_DEPTH  = 2,
   parameter int RX_DEPTH  = 2,
   parameter bit STEREO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_tx_en,
   input  logic              cmd_tx_dis,
   input  logic              cmd_rx_en,
   input  logic              cmd_rx_dis,
   input  logic              cfg_tx_half,
   input  logic              cfg_auto_tri,
   input  logic              cfg_stereo,
   input  logic              rx_block,
   input  logic              tx_wr_valid,
   input  logic [DATA_W-1:0] tx_wr_data,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_load_data,
   input  logic              tx_frame_done,
   input  logic              rx_frame_start,
   input  logic              rx_frame_done,
   input  logic [DATA_W-1:0] rx_frame_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_rd_data,
   output logic              tx_level,
   output logic              tx_complete,
   output logic              tx_tristated,
   output logic              rx_valid,
   output logic              rx_full,
   output logic              rx_right_next,
   output logic              rx_full_right,
   output logic              tx_exp_right,
   output logic              tx_exp_dright
);

   if (TX_DEPTH < 2 || RX_DEPTH < 2) begin : g_bad_depth
      $error("sbuf_status_ctrl: buffer depths must be at least 2");
   end

   logic tx_on, rx_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_on <= 1'b0;
         rx_on <= 1'b0;
      end else begin
         if (cmd_tx_dis)     tx_on <= 1'b0;
         else if (cmd_tx_en) tx_on <= 1'b1;
         if (cmd_rx_dis)     rx_on <= 1'b0;
         else if (cmd_rx_en) rx_on <= 1'b1;
      end
   end

   assign tx_tristated = !cfg_auto_tri && !tx_on;

   sbuf_tx #(.W(DATA_W), .DEPTH(TX_DEPTH), .STEREO_EN(STEREO_EN)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_on),
      .wr_valid   (tx_wr_valid),
      .wr_data    (tx_wr_data),
      .frame_done (tx_frame_done),
      .half_sel   (cfg_tx_half),
      .stereo     (cfg_stereo),
      .load       (tx_load),
      .load_data  (tx_load_data),
      .level      (tx_level),
      .complete   (tx_complete),
      .exp_right  (tx_exp_right),
      .exp_dright (tx_exp_dright)
   );

   sbuf_rx #(.W(DATA_W), .DEPTH(RX_DEPTH), .STEREO_EN(STEREO_EN)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_en       (rx_on),
      .dis_cmd     (cmd_rx_dis),
      .frame_start (rx_frame_start),
      .frame_done  (rx_frame_done),
      .frame_data  (rx_frame_data),
      .block       (rx_block),
      .rd          (rx_rd),
      .stereo      (cfg_stereo),
      .rd_data     (rx_rd_data),
      .valid       (rx_valid),
      .full        (rx_full),
      .right_next  (rx_right_next),
      .full_right  (rx_full_right)
   );

endmodule

// File: rtl/sbuf_status_chk.sv
module sbuf_status_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_tx_dis,
   input logic cfg_tx_half,
   input logic tx_wr_valid,
   input logic tx_load,
   input logic tx_level,
   input logic tx_complete,
   input logic rx_frame_done,
   input logic rx_valid,
   input logic rx_full
);

   a_r1_dis_stops_load: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_tx_dis |=> !tx_load);

   a_r2_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);

   a_r3_empty_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_tx_half && tx_level) |-> !tx_load);

   a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_valid |=> !tx_complete);

   a_r6_valid_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(rx_frame_done));

   a_r7_full_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_valid);

endmodule

bind sbuf_status_ctrl sbuf_status_chk u_chk (.*);

// File: tb/tb_sbuf_status_ctrl.sv
module tb_sbuf_status_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_tx_en = 0, cmd_tx_dis = 0, cmd_rx_en = 0, cmd_rx_dis = 0;
   logic       cfg_tx_half = 0, cfg_auto_tri = 0, cfg_stereo = 0, rx_block = 0;
   logic       tx_wr_valid = 0, tx_frame_done = 0;
   logic [7:0] tx_wr_data = '0, rx_frame_data = '0;
   logic       rx_frame_start = 0, rx_frame_done = 0, rx_rd = 0;
   logic       tx_load, tx_level, tx_complete, tx_tristated;
   logic [7:0] tx_load_data, rx_rd_data;
   logic       rx_valid, rx_full, rx_right_next, rx_full_right;
   logic       tx_exp_right, tx_exp_dright;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   sbuf_status_ctrl dut (.*);

   // {wr, tx_done, rx_done, rd | exp tx_level, tx_complete, rx_valid, rx_full}
   localparam logic [7:0] VEC [14] = '{
      8'b1010_0010, 8'b0010_1011, 8'b1010_0011, 8'b1010_0011,
      8'b1001_0010, 8'b0100_0011, 8'b0001_0010, 8'b0101_0000,
      8'b0000_1000, 8'b0100_1100, 8'b0000_1100, 8'b1000_0000,
      8'b0000_1000, 8'b0100_1100
   };
   localparam logic [7:0] LD_EXP [4] = '{8'hA0, 8'hA2, 8'hA3, 8'hAB};

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmd_tx_en = 0; cmd_tx_dis = 0; cmd_rx_en = 0; cmd_rx_dis = 0;
      tx_wr_valid = 0; tx_frame_done = 0;
      rx_frame_start = 0; rx_frame_done = 0; rx_rd = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rx_frame(input logic [7:0] d);
      rx_frame_done = 1; rx_frame_data = d;
      step();
   endtask

   initial begin
      int ld_idx;
      int rd_idx;
      do_reset();
      // reset state
      chk("R3", "tx_level reset", tx_level, 1);
      chk("R4", "tx_complete reset", tx_complete, 0);
      chk("R6", "rx_valid reset", rx_valid, 0);
      chk("R7", "rx_full reset", rx_full, 0);
      chk("R5", "tx_tristated reset", tx_tristated, 1);

      // R1: simultaneous enable and disable leaves receiver off
      cmd_rx_en = 1; cmd_rx_dis = 1; step();
      rx_frame(8'h55);
      chk("R1", "rx off after en+dis", rx_valid, 0);

      cmd_tx_en = 1; cmd_rx_en = 1; step();
      chk("R5", "tx_tristated enabled", tx_tristated, 0);

      ld_idx = 0;
      rd_idx = 0;
      for (int i = 0; i < 14; i++) begin
         logic [7:0] v;
         v = VEC[i];
         tx_wr_valid   = v[7];
         tx_wr_data    = 8'hA0 + 8'(i);
         tx_frame_done = v[6];
         rx_frame_done = v[5];
         rx_frame_data = 8'h10 + 8'(i);
         rx_rd         = v[4];
         #1;
         if (tx_load) begin
            if (ld_idx < 4) chk("R2", "tx_load_data", tx_load_data, LD_EXP[ld_idx]);
            else chk("R2", "extra tx_load", 1, 0);
            ld_idx++;
         end
         if (v[4]) begin
            chk("R7", "rx_rd_data order", rx_rd_data, 8'h10 + 8'(rd_idx));
            rd_idx++;
         end
         step();
         chk("R3", $sformatf("tx_level row %0d", i), tx_level, v[3]);
         chk("R4", $sformatf("tx_complete row %0d", i), tx_complete, v[2]);
         chk("R6", $sformatf("rx_valid row %0d", i), rx_valid, v[1]);
         chk("R7", $sformatf("rx_full row %0d", i), rx_full, v[0]);
      end
      chk("R2", "load count (full write ignored)", ld_idx, 4);

      // R1/R5: transmitter off via simultaneous strobes
      cmd_tx_en = 1; cmd_tx_dis = 1; step();
      chk("R5", "tx_tristated when off", tx_tristated, 1);
      tx_wr_valid = 1; tx_wr_data = 8'hB0; step();
      chk("R1", "no load while tx off", tx_load, 0);
      chk("R3", "level one word, empty threshold", tx_level, 0);
      chk("R4", "write clears complete", tx_complete, 0);
      cfg_tx_half = 1; #1;
      chk("R3", "level one word, half threshold", tx_level, 1);
      tx_wr_valid = 1; tx_wr_data = 8'hB1; step();
      chk("R3", "level two words, half threshold", tx_level, 0);
      cfg_auto_tri = 1; #1;
      chk("R5", "auto tristate reads 0", tx_tristated, 0);
      cfg_auto_tri = 0; cfg_tx_half = 0;
      cmd_tx_en = 1; step();
      chk("R2", "load after enable", tx_load, 1);
      chk("R2", "load data oldest", tx_load_data, 8'hB0);

      // R8: disable mid-frame then re-enable
      rx_frame_start = 1; step();
      cmd_rx_dis = 1; step();
      cmd_rx_en = 1; step();
      rx_frame(8'h66);
      chk("R8", "aborted frame dropped", rx_valid, 0);
      rx_frame_start = 1; step();
      rx_frame(8'h77);
      chk("R8", "next frame accepted", rx_valid, 1);
      chk("R6", "rx_rd_data head", rx_rd_data, 8'h77);
      rx_rd = 1; step();
      chk("R6", "read empties buffer", rx_valid, 0);

      // R9: blocked frame discarded
      rx_block = 1; rx_frame(8'h88);
      chk("R9", "blocked frame dropped", rx_valid, 0);
      rx_block = 0;

      // stereo
      cfg_stereo = 1;
      do_reset();
      chk("R11", "tx_exp_right after reset", tx_exp_right, 0);
      chk("R11", "tx_exp_dright after reset", tx_exp_dright, 0);
      tx_wr_valid = 1; tx_wr_data = 8'hC0; step();
      chk("R11", "next write right", tx_exp_right, 1);
      chk("R11", "dright needs empty", tx_exp_dright, 0);
      cmd_tx_en = 1; step();
      step();
      chk("R11", "dright when empty", tx_exp_dright, 1);

      cmd_rx_en = 1; step();
      rx_frame(8'h20);
      chk("R10", "left head", rx_right_next, 0);
      rx_frame(8'h21);
      chk("R10", "mixed full not right", rx_full_right, 0);
      chk("R7", "stereo full", rx_full, 1);
      rx_rd = 1; step();
      chk("R10", "right head after read", rx_right_next, 1);
      rx_block = 1; rx_frame(8'h22);
      rx_block = 0;
      chk("R9", "blocked stereo frame dropped", rx_full, 0);
      rx_frame(8'h23);
      chk("R10", "full of right data", rx_full_right, 1);
      chk("R10", "right head kept", rx_right_next, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule